// File: doc/BRIEF.md
# Routing table indirect access controller

This block holds the destination-ID routing tables of a multi-port packet switch, one table per port. Each table maps a destination ID to the egress port number that packets carrying that ID should leave through. Software never addresses table entries directly. It first loads an index register with a destination ID. It then reads or writes a companion port register, and that access reaches the selected entry.

There are two ways in. A global index/port pair writes the selected entry in every port's table at once, and it reads from port 0's table only. Each port also has a private pair that reaches only its own table. A private pair can advance its index by one after every access, so software can stream through a whole table without reloading the index. A port number larger than the switch's port count is stored as a reserved "no route" code.

Each port also has its own lookup interface for the forwarding path. It takes a destination ID and returns the stored egress port one cycle later.

Top module: `rt_idx_ctrl`

## Requirements
- R1: The global index register sits at byte offset 0x70 and the global port register at 0x74. An access to 0x74 reaches the entry selected by the destination ID last written to 0x70. Reading 0x70 returns that ID in its low DID_W bits.
- R2: A write to 0x74 stores the same value into the selected entry of every port's table in the same cycle.
- R3: A read of 0x74 returns the selected entry of port 0's table, whatever the other tables hold.
- R4: In a port register, the port number occupies bits 7:0 and only those bits are written. Bits 31:8 of every port register read back as zero.
- R5: A written port number greater than NPORTS is stored as 0xFF. Values from 0 up to NPORTS are stored as written. An entry holding 0xFF reads back, and is looked up, as 0xFF.
- R6: The private pair of port p has its index register at 0x100 + 16·p and its port register at 0x104 + 16·p. A write through a private port register changes only port p's table, and a read returns port p's entry.
- R7: A private index register holds the destination ID in bits DID_W-1:0 and an auto-advance enable in bit 31. Both read back. While the enable is set, every read or write of that port's private port register is followed by the index advancing by one, wrapping from 2^DID_W − 1 to 0. While the enable is clear, the index does not change.
- R8: `rvalid` is high for exactly one cycle in the cycle after each read request. Writes and idle cycles produce no `rvalid`. After reset `rvalid` is low.
- R9: Reads of unassigned or unaligned offsets return zero. Writes to them change no register and no table entry.
- R10: Offset 0x10 reads the port count NPORTS in its low bits. Writes to it are ignored.
- R11: When `lk_vld[p]` is high, `lk_ovld[p]` is high in the next cycle, and `lk_port` byte p carries port p's entry for `lk_did` field p. If a register write hits the same entry in the same cycle, the lookup returns the value from before the write. After reset `lk_ovld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request, one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte offset of the register |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Read data |
| lk_vld | input | NPORTS | Per-port lookup request |
| lk_did | input | NPORTS·DID_W | Per-port destination ID to look up, field p for port p |
| lk_ovld | output | NPORTS | Per-port lookup result valid |
| lk_port | output | NPORTS·8 | Per-port egress port result, byte p for port p |

## Verification
The bench builds the block with NPORTS = 4 and DID_W = 4. With these values every table has 16 entries. The auto-advance wrap from 15 to 0 is reached within a few accesses. The boundary between a storable port number (4) and one that becomes unmapped (5) sits in the low byte, where random data crosses it often. Because the tables are so small, a random mix of global and private accesses, together with lookups on all four ports, keeps colliding on the same entries. This exercises broadcast against isolation, and write-versus-lookup ordering, on every clock.

// File: rtl/rt_pkg.sv
package rt_pkg;

   localparam logic [7:0] PORT_NONE = 8'hFF;

   localparam int unsigned OFF_NPORT  = 32'h010;
   localparam int unsigned OFF_G_DID  = 32'h070;
   localparam int unsigned OFF_G_PORT = 32'h074;
   localparam int unsigned OFF_PBASE  = 32'h100;
   localparam int unsigned P_STRIDE_LG = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_NPORT,
      SEL_G_DID,
      SEL_G_PORT,
      SEL_P_DID,
      SEL_P_PORT
   } sel_e;

   typedef struct packed {
      sel_e       sel;
      logic [7:0] pidx;
   } dec_t;

endpackage

// File: rtl/rt_addr_dec.sv
module rt_addr_dec #(
   parameter int NPORTS = 8,
   parameter int AW     = 12
) (
   input  logic [AW-1:0] addr,
   output rt_pkg::dec_t  dec
);
   import rt_pkg::*;

   localparam logic [AW-1:0] A_NPORT  = AW'(OFF_NPORT);
   localparam logic [AW-1:0] A_G_DID  = AW'(OFF_G_DID);
   localparam logic [AW-1:0] A_G_PORT = AW'(OFF_G_PORT);
   localparam logic [AW-1:0] A_PBASE  = AW'(OFF_PBASE);

   logic [AW-1:0] off;
   assign off = addr - A_PBASE;

   always_comb begin
      dec.sel  = SEL_NONE;
      dec.pidx = 8'(off[AW-1:P_STRIDE_LG]);
      if (addr == A_NPORT) begin
         dec.sel = SEL_NPORT;
      end else if (addr == A_G_DID) begin
         dec.sel = SEL_G_DID;
      end else if (addr == A_G_PORT) begin
         dec.sel = SEL_G_PORT;
      end else if (addr >= A_PBASE && int'(off[AW-1:P_STRIDE_LG]) < NPORTS
                   && off[1:0] == 2'b00) begin
         if (off[3:2] == 2'd0)      dec.sel = SEL_P_DID;
         else if (off[3:2] == 2'd1) dec.sel = SEL_P_PORT;
      end
   end

endmodule

// File: rtl/rt_port_ctx.sv
module rt_port_ctx #(
   parameter int DID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [DID_W-1:0] ld_did,
   input  logic             ld_ai,
   input  logic             touch,
   output logic [DID_W-1:0] did,
   output logic             ai
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         did <= '0;
         ai  <= 1'b0;
      end else if (ld) begin
         did <= ld_did;
         ai  <= ld_ai;
      end else if (touch && ai) begin
         did <= did + DID_W'(1);
      end
   end

endmodule

// File: rtl/rt_table.sv
module rt_table #(
   parameter int DID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [DID_W-1:0] idx,
   input  logic [7:0]       wval,
   output logic [7:0]       cval,
   input  logic             lk_vld,
   input  logic [DID_W-1:0] lk_did,
   output logic             lk_ovld,
   output logic [7:0]       lk_port
);
   localparam int NE = 1 << DID_W;

   logic [7:0] mem [NE];

   assign cval = mem[idx];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wval;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_ovld <= 1'b0;
         lk_port <= '0;
      end else begin
         lk_ovld <= lk_vld;
         if (lk_vld) lk_port <= mem[lk_did];
      end
   end

endmodule

// File: rtl/rt_idx_ctrl.sv
module rt_idx_ctrl #(
   parameter int NPORTS = 8,
   parameter int DID_W  = 8,
   parameter int AW     = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic                    we,
   input  logic [AW-1:0]           addr,
   input  logic [31:0]             wdata,
   output logic                    rvalid,
   output logic [31:0]             rdata,
   input  logic [NPORTS-1:0]       lk_vld,
   input  logic [NPORTS*DID_W-1:0] lk_did,
   output logic [NPORTS-1:0]       lk_ovld,
   output logic [NPORTS*8-1:0]     lk_port
);
   import rt_pkg::*;

   localparam logic [7:0] NP_B = 8'(NPORTS);

   if (NPORTS < 1 || NPORTS > 200) begin : g_bad_np
      $error("rt_idx_ctrl: NPORTS must lie in 1..200");
   end
   if (DID_W < 1 || DID_W > 16) begin : g_bad_did
      $error("rt_idx_ctrl: DID_W must lie in 1..16");
   end
   if (AW > 32 || (OFF_PBASE + NPORTS * (1 << P_STRIDE_LG)) > (1 << AW)) begin : g_bad_aw
      $error("rt_idx_ctrl: AW too small for the per-port register window");
   end

   dec_t dec;
   rt_addr_dec #(.NPORTS(NPORTS), .AW(AW)) u_dec (.addr(addr), .dec(dec));

   logic wr;
   logic [DID_W-1:0] g_did;
   logic [7:0] enc_port;
   logic [NPORTS-1:0][DID_W-1:0] p_did;
   logic [NPORTS-1:0] ai;
   logic [NPORTS-1:0] tbl_we;
   logic [NPORTS-1:0][7:0] cval;
   logic unused_wdata;

   assign wr           = req && we;
   assign enc_port     = (wdata[7:0] > NP_B) ? PORT_NONE : wdata[7:0];
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_did <= '0;
      else if (wr && dec.sel == SEL_G_DID) g_did <= wdata[DID_W-1:0];
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic hit;
      logic [DID_W-1:0] idx;

      assign hit       = (dec.pidx == 8'(p));
      assign tbl_we[p] = wr && (dec.sel == SEL_G_PORT || (dec.sel == SEL_P_PORT && hit));
      assign idx       = (dec.sel == SEL_G_PORT) ? g_did : p_did[p];

      rt_port_ctx #(.DID_W(DID_W)) u_ctx (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (wr && dec.sel == SEL_P_DID && hit),
         .ld_did (wdata[DID_W-1:0]),
         .ld_ai  (wdata[31]),
         .touch  (req && dec.sel == SEL_P_PORT && hit),
         .did    (p_did[p]),
         .ai     (ai[p])
      );

      rt_table #(.DID_W(DID_W)) u_tbl (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (tbl_we[p]),
         .idx     (idx),
         .wval    (enc_port),
         .cval    (cval[p]),
         .lk_vld  (lk_vld[p]),
         .lk_did  (lk_did[p*DID_W +: DID_W]),
         .lk_ovld (lk_ovld[p]),
         .lk_port (lk_port[p*8 +: 8])
      );
   end

   logic [31:0] rnext;
   always_comb begin
      rnext = '0;
      case (dec.sel)
         SEL_NPORT:  rnext = 32'(NPORTS);
         SEL_G_DID:  rnext = 32'(g_did);
         SEL_G_PORT: rnext = {24'b0, cval[0]};
         SEL_P_DID: begin
            for (int p = 0; p < NPORTS; p++)
               if (dec.pidx == 8'(p)) rnext = {ai[p], (31-DID_W)'(0), p_did[p]};
         end
         SEL_P_PORT: begin
            for (int p = 0; p < NPORTS; p++)
               if (dec.pidx == 8'(p)) rnext = {24'b0, cval[p]};
         end
         default: rnext = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= req && !we;
         if (req && !we) rdata <= rnext;
      end
   end

endmodule

// File: rtl/rt_idx_ctrl_chk.sv
module rt_idx_ctrl_chk #(
   parameter int NPORTS = 8,
   parameter int DID_W  = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req,
   input logic                         we,
   input rt_pkg::sel_e                 sel,
   input logic [7:0]                   pidx,
   input logic                         rvalid,
   input logic [31:0]                  rdata,
   input logic [NPORTS-1:0]            lk_vld,
   input logic [NPORTS-1:0]            lk_ovld,
   input logic [NPORTS*8-1:0]          lk_port,
   input logic [NPORTS-1:0]            tbl_we,
   input logic [NPORTS-1:0][DID_W-1:0] p_did,
   input logic [NPORTS-1:0]            ai
);
   import rt_pkg::*;

   p_rd_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we) |=> rvalid) else $error("read without response");

   p_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(req && !we) |=> !rvalid) else $error("response without read");

   p_port_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && (sel == SEL_G_PORT || sel == SEL_P_PORT)) |=> (rdata[31:8] == 24'd0))
      else $error("reserved port bits not zero");

   p_private_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && sel == SEL_P_PORT) |-> ($countones(tbl_we) == 1))
      else $error("private write reached several tables");

   for (genvar p = 0; p < NPORTS; p++) begin : g_p
      p_lk_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
         lk_vld[p] |=> lk_ovld[p]) else $error("lookup result missing");

      p_lk_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
         lk_ovld[p] |-> (lk_port[p*8 +: 8] <= 8'(NPORTS) || lk_port[p*8 +: 8] == PORT_NONE))
         else $error("lookup returned an out-of-range code");

      p_ai_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (req && sel == SEL_P_PORT && pidx == 8'(p) && ai[p])
         |=> (p_did[p] == $past(p_did[p]) + DID_W'(1)))
         else $error("index did not advance");

      p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !(req && (sel == SEL_P_PORT || (we && sel == SEL_P_DID)) && pidx == 8'(p))
         |=> $stable(p_did[p])) else $error("index moved without access");
   end

endmodule

bind rt_idx_ctrl rt_idx_ctrl_chk #(.NPORTS(NPORTS), .DID_W(DID_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req     (req),
   .we      (we),
   .sel     (dec.sel),
   .pidx    (dec.pidx),
   .rvalid  (rvalid),
   .rdata   (rdata),
   .lk_vld  (lk_vld),
   .lk_ovld (lk_ovld),
   .lk_port (lk_port),
   .tbl_we  (tbl_we),
   .p_did   (p_did),
   .ai      (ai)
);

// File: tb/tb_rt_idx_ctrl.sv
`timescale 1ns/1ps
module tb_rt_idx_ctrl;
   localparam int NP = 4;
   localparam int DW = 4;
   localparam int AW = 12;
   localparam int NE = 1 << DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic rvalid;
   logic [31:0] rdata;
   logic [NP-1:0] lk_vld = '0;
   logic [NP*DW-1:0] lk_did = '0;
   logic [NP-1:0] lk_ovld;
   logic [NP*8-1:0] lk_port;

   rt_idx_ctrl #(.NPORTS(NP), .DID_W(DW), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .rvalid(rvalid), .rdata(rdata), .lk_vld(lk_vld), .lk_did(lk_did),
      .lk_ovld(lk_ovld), .lk_port(lk_port));

   int checks = 0, errors = 0;
   int tbl [NP][NE];
   int g_did = 0;
   int p_did [NP];
   bit ai [NP];

   bit e_rv = 1'b0;
   logic [31:0] e_rd = '0;
   string e_tag = "R8";
   bit e_lkv = 1'b0;
   int e_lk [NP];
   string e_lktag = "R11";

   function automatic int enc(logic [31:0] d);
      int v = int'(d[7:0]);
      return (v > NP) ? 255 : v;
   endfunction

   task automatic check();
      checks++;
      if (rvalid !== e_rv) begin
         errors++;
         $display("FAIL R8: rvalid got %b expected %b", rvalid, e_rv);
      end
      if (e_rv) begin
         checks++;
         if (rdata !== e_rd) begin
            errors++;
            $display("FAIL %s: rdata got %h expected %h", e_tag, rdata, e_rd);
         end
      end
      for (int p = 0; p < NP; p++) begin
         checks++;
         if (lk_ovld[p] !== e_lkv) begin
            errors++;
            $display("FAIL R11: lk_ovld[%0d] got %b expected %b", p, lk_ovld[p], e_lkv);
         end
         if (e_lkv) begin
            checks++;
            if (lk_port[p*8 +: 8] !== 8'(e_lk[p])) begin
               errors++;
               $display("FAIL %s: lk_port[%0d] got %h expected %h", e_lktag, p,
                        lk_port[p*8 +: 8], 8'(e_lk[p]));
            end
         end
      end
   endtask

   task automatic step(bit rq, bit w, int a, logic [31:0] d, string tag,
                       bit lkv = 1'b0, int ld = 0);
      bit inport;
      int p, r;
      @(negedge clk);
      check();
      req = rq; we = w; addr = AW'(a); wdata = d;
      lk_vld = {NP{lkv}};
      lk_did = {NP{DW'(ld)}};
      e_lkv = lkv; e_lktag = tag;
      for (int q = 0; q < NP; q++) e_lk[q] = tbl[q][ld % NE];
      e_rv = rq && !w; e_rd = '0; e_tag = tag;
      inport = (a >= 256) && (a < 256 + NP*16) && (a % 4 == 0);
      p = (a - 256) / 16;
      r = (a - 256) % 16;
      if (rq) begin
         if (a == 'h10) begin
            if (!w) e_rd = NP;
         end else if (a == 'h70) begin
            if (w) g_did = int'(d[DW-1:0]); else e_rd = g_did;
         end else if (a == 'h74) begin
            if (w) for (int q = 0; q < NP; q++) tbl[q][g_did] = enc(d);
            else e_rd = tbl[0][g_did];
         end else if (inport && r == 0) begin
            if (w) begin p_did[p] = int'(d[DW-1:0]); ai[p] = d[31]; end
            else e_rd = {ai[p], 31'(p_did[p])};
         end else if (inport && r == 4) begin
            if (w) tbl[p][p_did[p]] = enc(d); else e_rd = tbl[p][p_did[p]];
            if (ai[p]) p_did[p] = (p_did[p] + 1) % NE;
         end
      end
   endtask

   task automatic wr(int a, logic [31:0] d, string tag);
      step(1'b1, 1'b1, a, d, tag);
   endtask
   task automatic rd(int a, string tag);
      step(1'b1, 1'b0, a, '0, tag);
   endtask
   task automatic lk(int d, string tag);
      step(1'b0, 1'b0, 0, '0, tag, 1'b1, d);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int q = 0; q < NP; q++) begin p_did[q] = 0; ai[q] = 1'b0; end
      // R8: reset state of rvalid and lookup valid
      step(1'b0, 1'b0, 0, '0, "R8");
      step(1'b0, 1'b0, 0, '0, "R8");
      rst_n = 1'b1;

      // R1 / R5: fill every entry of every table with the unmapped code
      for (int i = 0; i < NE; i++) begin
         wr('h70, i, "R1");
         wr('h74, 32'hFF, "R5");
      end
      for (int i = 0; i < NE; i++) lk(i, "R5");
      rd('h70, "R1");

      // R2 / R3 / R4: broadcast write, global read from port 0
      wr('h70, 3, "R1");
      wr('h74, 32'hABCD_EF02, "R4");
      lk(3, "R2");
      rd('h74, "R4");
      wr('h100 + 2*16, 3, "R6");
      wr('h104 + 2*16, 1, "R6");
      lk(3, "R6");
      rd('h104 + 2*16, "R6");
      rd('h74, "R3");
      wr('h100, 3, "R6");
      wr('h104, 0, "R3");
      rd('h74, "R3");

      // R5: port-count boundary
      wr('h70, 7, "R1");
      wr('h74, NP, "R5");
      lk(7, "R5");
      wr('h74, NP + 1, "R5");
      lk(7, "R5");
      rd('h74, "R5");
      wr('h74, 32'h1234_5603, "R4");
      rd('h74, "R4");

      // R7: auto-advance with wrap
      wr('h110, 32'h8000_000E, "R7");
      rd('h110, "R7");
      wr('h114, 2, "R7");
      wr('h114, 1, "R7");
      rd('h110, "R7");
      rd('h114, "R7");
      rd('h110, "R7");
      lk(14, "R7");
      lk(15, "R7");
      wr('h130, 5, "R7");
      rd('h134, "R7");
      rd('h134, "R7");
      rd('h130, "R7");

      // R9 / R10: unassigned offsets and port count register
      wr('h10, 99, "R10");
      rd('h10, "R10");
      wr('h0, 32'hFFFF_FFFF, "R9");
      rd('h0, "R9");
      rd('h78, "R9");
      wr('h100 + NP*16 + 4, 2, "R9");
      wr('h106, 2, "R9");
      wr('h108, 2, "R9");
      rd('h100 + NP*16, "R9");
      rd('h108, "R9");
      for (int i = 0; i < NE; i++) lk(i, "R9");

      // R8: back-to-back reads then idle
      rd('h70, "R8");
      rd('h10, "R8");
      step(1'b0, 1'b0, 0, '0, "R8");

      // R11: write and lookup of the same entry in one cycle
      wr('h70, 5, "R1");
      step(1'b1, 1'b1, 'h74, 2, "R11", 1'b1, 5);
      lk(5, "R11");
      wr('h150, 32'h8000_0009, "R7");
      step(1'b1, 1'b1, 'h154, 1, "R11", 1'b1, 9);
      lk(9, "R11");

      // mixed random traffic with lookups on every cycle
      for (int n = 0; n < 600; n++) begin
         int a;
         logic [31:0] d;
         case ($urandom % 8)
            0: a = 'h10;
            1: a = 'h70;
            2: a = 'h74;
            3: a = 'h100 + 16 * int'($urandom % NP);
            4, 5, 6: a = 'h104 + 16 * int'($urandom % NP);
            default: a = int'($urandom % 512);
         endcase
         d = $urandom;
         d[7:0] = 8'($urandom % 8);
         step(($urandom % 4) != 0, $urandom % 2, a, d, "R11",
              ($urandom % 3) != 0, int'($urandom % NE));
      end
      step(1'b0, 1'b0, 0, '0, "R8");
      step(1'b0, 1'b0, 0, '0, "R8");
      @(negedge clk);
      check();
      finish_run();
   end

endmodule